// File: doc/BRIEF.md
# Endpoint Configuration Space Register File

This block holds the 256-byte configuration header of a single type-0 endpoint function. A host-side access port reads or writes one, two or four bytes at any byte offset. Writes pass through a fixed table of read-only bytes and a mask on the reserved command bits. Dword writes to the base address slots follow their own rule: address bits below the region size are cleared and the region type bit is kept, so software can probe a region's size by writing all ones and reading the value back.

The command register, the six base address values and the expansion ROM value are driven out continuously to a downstream address-window decoder. A one-cycle remap pulse tells that decoder to re-evaluate its windows whenever the command register or a base address changes. Identity fields, class code, interrupt pin and region sizes are parameters. An I/O region sets bit 0 of its slot; a memory region leaves it clear.

Top module: `cfg_space`

## Requirements
- R1: After reset, offsets 0x00-0x03 hold vendor and device ID, 0x08 holds the revision, 0x09-0x0B hold the class code, 0x2C-0x2F hold the subsystem vendor and subsystem ID, and 0x3D holds the interrupt pin. Each implemented I/O base slot holds 0x00000001. Every other byte, including command and status, holds zero.
- R2: A read returns data combinationally in the same cycle. The size code is acc_size: 0 is byte, 1 is word, 2 or 3 is dword. Data is little-endian, so the lowest offset is in bits [7:0], and unused upper bits are zero.
- R3: A dword read is served as a dword only at offsets up to 0xFC; above that it becomes a word read. A word read is served only at offsets up to 0xFE; above that it becomes a byte read.
- R4: A write updates its bytes one at a time from the lowest offset upward, and bytes past offset 0xFF are dropped.
- R5: Bytes 0x00-0x03, 0x06-0x0B, 0x0E, 0x2C-0x2F and 0x3D never change on a write.
- R6: Byte 0x04 is fully writable. In byte 0x05 only bits [2:0] (command bits 10:8) store, and the rest read zero.
- R7: A dword write at offset 0x10+4n (n = 0 to 5) to an implemented slot stores (wdata AND NOT(size-1)) OR the type bit, where the type bit is 1 for I/O and 0 for memory.
- R8: A dword write at offset 0x30, when a ROM region exists, stores wdata AND (NOT(size-1) OR 1), so bit 0 stays writable as the enable.
- R9: An unimplemented base slot or ROM reads as zero and ignores writes. Byte 0x10-0x27 and 0x30-0x33 ignore any write that is not an aligned dword to the slot start.
- R10: One cycle after a write that covers offset 0x04 or 0x05, or a dword write to an implemented base or ROM slot, remap is high for one cycle. After any other cycle it is low.
- R11: cmd, bar_vals and rom_val always show the stored command word, the six base slots (slot n in bits [32n+31:32n]) and the ROM slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Access valid this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_off | input | 8 | Byte offset of the access |
| acc_size | input | 2 | 0 byte, 1 word, 2/3 dword |
| wdata | input | 32 | Write data, little-endian |
| rdata | output | 32 | Read data, same cycle |
| cmd | output | 16 | Command register |
| bar_vals | output | 192 | Six base address slots |
| rom_val | output | 32 | Expansion ROM slot |
| remap | output | 1 | Window re-evaluation pulse |

## Verification
The assertions assume several things about the inputs. acc_en, acc_wr, acc_off, acc_size and wdata are known and held steady around each rising edge, and no access arrives while reset is asserted. A read is judged only in the cycle it is presented. The stimulus drives every input just after a falling edge and lowers acc_en on idle cycles, so each access occupies exactly one clock. Random offsets are biased toward the header so that the protected bytes, the base slots and the command word are hit often, and the size code covers all four values, including the dword alias 3.

// File: rtl/cfg_space.sv
module cfg_space #(
  parameter logic [15:0]  VENDOR_ID  = 16'h1D0F,
  parameter logic [15:0]  DEVICE_ID  = 16'h0042,
  parameter logic [7:0]   REVISION   = 8'h02,
  parameter logic [23:0]  CLASS_CODE = 24'h028000,
  parameter logic [15:0]  SUB_VENDOR = 16'h1D0F,
  parameter logic [15:0]  SUB_ID     = 16'h0001,
  parameter logic [7:0]   INT_PIN    = 8'h01,
  parameter logic [191:0] BAR_SIZES  = {32'h0, 32'h0, 32'h0, 32'h0, 32'h0000_1000, 32'h0000_0020},
  parameter logic [5:0]   BAR_IO     = 6'b000001,
  parameter logic [31:0]  ROM_SIZE   = 32'h0000_8000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         acc_en,
  input  logic         acc_wr,
  input  logic [7:0]   acc_off,
  input  logic [1:0]   acc_size,
  input  logic [31:0]  wdata,
  output logic [31:0]  rdata,
  output logic [15:0]  cmd,
  output logic [191:0] bar_vals,
  output logic [31:0]  rom_val,
  output logic         remap
);
  localparam int NBAR = 6;
  localparam int NBYTES = 256;
  localparam logic [7:0] CMD_HI_MASK = 8'h07;
  localparam logic [7:0] BAR_FIRST = 8'h10;
  localparam logic [7:0] BAR_LAST = 8'h24;
  localparam logic [7:0] ROM_OFF = 8'h30;

  logic [7:0] cfg [NBYTES];

  function automatic logic [7:0] init_byte(input logic [7:0] a);
    logic [2:0] idx;
    idx = 3'((a - BAR_FIRST) >> 2);
    case (a)
      8'h00: return VENDOR_ID[7:0];
      8'h01: return VENDOR_ID[15:8];
      8'h02: return DEVICE_ID[7:0];
      8'h03: return DEVICE_ID[15:8];
      8'h08: return REVISION;
      8'h09: return CLASS_CODE[7:0];
      8'h0A: return CLASS_CODE[15:8];
      8'h0B: return CLASS_CODE[23:16];
      8'h2C: return SUB_VENDOR[7:0];
      8'h2D: return SUB_VENDOR[15:8];
      8'h2E: return SUB_ID[7:0];
      8'h2F: return SUB_ID[15:8];
      8'h3D: return INT_PIN;
      default: begin
        if (a >= BAR_FIRST && a <= BAR_LAST && a[1:0] == 2'b00 &&
            BAR_IO[idx] && BAR_SIZES[{idx, 5'd0} +: 32] != 32'h0)
          return 8'h01;
        return 8'h00;
      end
    endcase
  endfunction

  function automatic logic ro_byte(input logic [7:0] a);
    return (a <= 8'h03) || (a >= 8'h06 && a <= 8'h0B) || (a == 8'h0E) ||
           (a >= 8'h10 && a <= 8'h27) || (a >= 8'h2C && a <= 8'h33) || (a == 8'h3D);
  endfunction

  wire        wr = acc_en & acc_wr;
  wire        dw = acc_size[1];
  wire [2:0]  nbytes = dw ? 3'd4 : (acc_size[0] ? 3'd2 : 3'd1);
  wire [7:0]  boff = acc_off - BAR_FIRST;
  wire [2:0]  bar_idx = boff[4:2];
  wire        bar_hit = dw && acc_off[1:0] == 2'b00 && acc_off >= BAR_FIRST && acc_off <= BAR_LAST;
  wire        rom_hit = dw && acc_off == ROM_OFF;
  wire [31:0] bar_sz = BAR_SIZES[{bar_idx, 5'd0} +: 32];
  wire        bar_impl = bar_hit && bar_sz != 32'h0;
  wire        rom_impl = rom_hit && ROM_SIZE != 32'h0;
  wire [31:0] bar_word = (wdata & ~(bar_sz - 32'h1)) | {31'h0, BAR_IO[bar_idx]};
  wire [31:0] rom_word = wdata & (~(ROM_SIZE - 32'h1) | 32'h1);
  wire [31:0] slot_word = bar_impl ? bar_word : rom_word;
  wire        touch_cmd = acc_off <= 8'h05 && ({1'b0, acc_off} + {6'b0, nbytes}) > 9'd4;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBYTES; i++) cfg[i] <= init_byte(8'(i));
      remap <= 1'b0;
    end else begin
      remap <= wr && (touch_cmd || bar_impl || rom_impl);
      if (wr) begin
        if (bar_impl || rom_impl) begin
          for (int k = 0; k < 4; k++) cfg[acc_off + 8'(k)] <= slot_word[8*k +: 8];
        end else if (!(bar_hit || rom_hit)) begin
          for (int k = 0; k < 4; k++) begin
            if (k < int'(nbytes) && ({1'b0, acc_off} + 9'(k)) <= 9'd255 && !ro_byte(acc_off + 8'(k)))
              cfg[acc_off + 8'(k)] <= ((acc_off + 8'(k)) == 8'h05) ?
                                      (wdata[8*k +: 8] & CMD_HI_MASK) : wdata[8*k +: 8];
          end
        end
      end
    end
  end

  wire rd4 = dw && acc_off <= 8'hFC;
  wire rd2 = rd4 || ((dw || acc_size[0]) && acc_off <= 8'hFE);

  always_comb begin
    rdata = 32'h0;
    rdata[7:0] = cfg[acc_off];
    if (rd2) rdata[15:8] = cfg[acc_off + 8'd1];
    if (rd4) begin
      rdata[23:16] = cfg[acc_off + 8'd2];
      rdata[31:24] = cfg[acc_off + 8'd3];
    end
  end

  assign cmd = {cfg[5], cfg[4]};
  assign rom_val = {cfg[ROM_OFF + 8'd3], cfg[ROM_OFF + 8'd2], cfg[ROM_OFF + 8'd1], cfg[ROM_OFF]};

  for (genvar n = 0; n < NBAR; n++) begin : g_bar
    localparam logic [7:0] B = BAR_FIRST + 8'(4 * n);
    assign bar_vals[32*n +: 32] = {cfg[B + 8'd3], cfg[B + 8'd2], cfg[B + 8'd1], cfg[B]};
  end
endmodule

// File: rtl/cfg_space_chk.sv
module cfg_space_chk #(
  parameter logic [191:0] BAR_SIZES = '0,
  parameter logic [5:0]   BAR_IO    = '0,
  parameter logic [31:0]  ROM_SIZE  = '0
) (
  input logic         clk,
  input logic         rst_n,
  input logic         acc_en,
  input logic         acc_wr,
  input logic [7:0]   acc_off,
  input logic [1:0]   acc_size,
  input logic [31:0]  rdata,
  input logic [15:0]  cmd,
  input logic [191:0] bar_vals,
  input logic [31:0]  rom_val,
  input logic         remap
);
  // R10
  remap_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr && acc_off == 8'h04) |=> remap);

  // R10
  remap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    remap |-> $past(acc_en && acc_wr));

  // R9
  narrow_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr && !acc_size[1]) |=> ($stable(bar_vals) && $stable(rom_val)));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_en && acc_wr) |=> ($stable(cmd) && $stable(bar_vals) && $stable(rom_val)));

  // R6
  cmd_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd[15:11] == 5'h0);

  // R2
  cmd_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr && acc_off == 8'h04 && acc_size == 2'd1) |-> rdata[15:0] == cmd);

  // R8
  rom_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_val & (ROM_SIZE - 32'h1) & ~32'h1) == 32'h0);

  for (genvar n = 0; n < 6; n++) begin : g_chk
    localparam logic [31:0] SZ = BAR_SIZES[32*n +: 32];
    // R7
    bar_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (SZ == 32'h0) ? (bar_vals[32*n +: 32] == 32'h0) :
      (((bar_vals[32*n +: 32] & (SZ - 32'h1)) >> 1) == 32'h0 && bar_vals[32*n] == BAR_IO[n]));
  end
endmodule

bind cfg_space cfg_space_chk #(.BAR_SIZES(BAR_SIZES), .BAR_IO(BAR_IO), .ROM_SIZE(ROM_SIZE)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr), .acc_off(acc_off),
  .acc_size(acc_size), .rdata(rdata), .cmd(cmd), .bar_vals(bar_vals),
  .rom_val(rom_val), .remap(remap)
);

// File: tb/cfg_space_bench.sv
module cfg_space_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, acc_en, acc_wr, remap;
  logic [7:0] acc_off;
  logic [1:0] acc_size;
  logic [31:0] wdata, rdata, rom_val;
  logic [15:0] cmd;
  logic [191:0] bar_vals;

  cfg_space u_cfg_space (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr), .acc_off(acc_off),
    .acc_size(acc_size), .wdata(wdata), .rdata(rdata), .cmd(cmd),
    .bar_vals(bar_vals), .rom_val(rom_val), .remap(remap)
  );

  int unsigned bsz [6] = '{32'h20, 32'h1000, 0, 0, 0, 0};
  bit bio [6] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
  int unsigned rsz = 32'h8000;
  logic [7:0] m [256];
  bit exp_remap;
  int nchk = 0, nbad = 0;

  function automatic void model_reset();
    for (int i = 0; i < 256; i++) m[i] = 8'h00;
    m[0] = 8'h0F; m[1] = 8'h1D; m[2] = 8'h42; m[3] = 8'h00;
    m[8] = 8'h02; m[9] = 8'h00; m[10] = 8'h80; m[11] = 8'h02;
    m[44] = 8'h0F; m[45] = 8'h1D; m[46] = 8'h01; m[47] = 8'h00;
    m[61] = 8'h01;
    for (int n = 0; n < 6; n++) if (bsz[n] != 0 && bio[n]) m[16 + 4*n] = 8'h01;
  endfunction

  function automatic bit ro(int a);
    return a <= 3 || (a >= 6 && a <= 11) || a == 14 || (a >= 16 && a <= 39) ||
           (a >= 44 && a <= 51) || a == 61;
  endfunction

  function automatic logic [31:0] m32(int a);
    return {m[a+3], m[a+2], m[a+1], m[a]};
  endfunction

  function automatic logic [31:0] model_read(int off, int sz);
    int len;
    logic [31:0] v;
    len = (sz >= 2 && off <= 252) ? 4 : ((sz >= 1 && off <= 254) ? 2 : 1);
    v = 0;
    for (int k = 0; k < len; k++) v[8*k +: 8] = m[off + k];
    return v;
  endfunction

  function automatic void store32(int a, logic [31:0] v);
    for (int k = 0; k < 4; k++) m[a + k] = v[8*k +: 8];
  endfunction

  function automatic void model_write(int off, int sz, logic [31:0] d);
    int n;
    n = sz >= 2 ? 4 : (sz == 1 ? 2 : 1);
    exp_remap = 0;
    if (n == 4 && off % 4 == 0 && off >= 16 && off <= 36) begin
      int idx;
      idx = (off - 16) / 4;
      if (bsz[idx] != 0) begin
        store32(off, (d & ~(bsz[idx] - 1)) | {31'h0, bio[idx]});
        exp_remap = 1;
      end
      return;
    end
    if (n == 4 && off == 48) begin
      if (rsz != 0) begin
        store32(off, d & (~(rsz - 1) | 32'h1));
        exp_remap = 1;
      end
      return;
    end
    exp_remap = (off <= 5) && (off + n > 4);
    for (int k = 0; k < n; k++) begin
      int a;
      a = off + k;
      if (a > 255) break;
      if (!ro(a)) m[a] = (a == 5) ? (d[8*k +: 8] & 8'h07) : d[8*k +: 8];
    end
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_outs();
    check("R10", {31'h0, remap}, {31'h0, exp_remap});
    check("R11", {16'h0, cmd}, {16'h0, m[5], m[4]});
    for (int n = 0; n < 6; n++) check("R11", bar_vals[32*n +: 32], m32(16 + 4*n));
    check("R11", rom_val, m32(48));
  endtask

  task automatic access(bit wr, int off, int sz, logic [31:0] d, string tag);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = wr; acc_off = 8'(off); acc_size = 2'(sz); wdata = d;
    #1;
    if (!wr) check(tag, rdata, model_read(off, sz));
    @(posedge clk);
    #1;
    if (wr) model_write(off, sz, d); else exp_remap = 0;
    check_outs();
  endtask

  task automatic idle();
    @(negedge clk);
    acc_en = 1'b0;
    @(posedge clk);
    #1;
    exp_remap = 0;
    check_outs();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; acc_en = 1'b0; acc_wr = 1'b0; acc_off = 8'h0; acc_size = 2'd0; wdata = 32'h0;
    model_reset();
    exp_remap = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", {16'h0, cmd}, 32'h0);
    check("R1", bar_vals[31:0], 32'h1);
    check("R1", bar_vals[63:32], 32'h0);
    check("R1", rom_val, 32'h0);
    for (int a = 0; a < 256; a += 4) access(1'b0, a, 2, 32'h0, "R1");

    access(1'b1, 4, 1, 32'h0000_FFFF, "R6");
    access(1'b0, 4, 1, 32'h0, "R6");
    access(1'b1, 5, 0, 32'h0000_00A5, "R6");
    access(1'b0, 4, 2, 32'h0, "R6");

    access(1'b1, 0, 2, 32'hFFFF_FFFF, "R5");
    access(1'b0, 0, 2, 32'h0, "R5");
    access(1'b1, 8'h0E, 0, 32'h0000_00FF, "R5");
    access(1'b1, 8'h3C, 1, 32'h0000_FFFF, "R5");
    access(1'b0, 8'h3C, 2, 32'h0, "R5");
    access(1'b1, 8'h2C, 2, 32'h1234_5678, "R5");
    access(1'b0, 8'h2C, 2, 32'h0, "R5");

    access(1'b1, 8'h10, 2, 32'hFFFF_FFFF, "R7");
    access(1'b0, 8'h10, 2, 32'h0, "R7");
    access(1'b1, 8'h14, 2, 32'h1234_5678, "R7");
    access(1'b0, 8'h14, 2, 32'h0, "R7");
    access(1'b1, 8'h11, 0, 32'h0000_00FF, "R9");
    access(1'b1, 8'h14, 1, 32'h0000_FFFF, "R9");
    access(1'b0, 8'h10, 2, 32'h0, "R9");
    access(1'b0, 8'h14, 2, 32'h0, "R9");
    access(1'b1, 8'h18, 2, 32'hFFFF_FFFF, "R9");
    access(1'b0, 8'h18, 2, 32'h0, "R9");
    access(1'b1, 8'h12, 3, 32'hFFFF_FFFF, "R9");
    access(1'b0, 8'h10, 2, 32'h0, "R9");

    access(1'b1, 8'h30, 2, 32'hFFFF_FFFF, "R8");
    access(1'b0, 8'h30, 2, 32'h0, "R8");
    access(1'b1, 8'h30, 3, 32'h0ABC_DEF0, "R8");
    access(1'b0, 8'h30, 2, 32'h0, "R8");
    access(1'b1, 8'h31, 0, 32'h0000_00FF, "R9");
    access(1'b0, 8'h30, 2, 32'h0, "R9");

    access(1'b1, 8'h40, 2, 32'hAABB_CCDD, "R4");
    access(1'b0, 8'h40, 0, 32'h0, "R4");
    access(1'b0, 8'h43, 0, 32'h0, "R4");
    access(1'b1, 8'hFE, 2, 32'h1122_3344, "R4");
    access(1'b0, 8'hFE, 1, 32'h0, "R4");
    access(1'b1, 8'h27, 2, 32'h5566_7788, "R4");
    access(1'b0, 8'h28, 2, 32'h0, "R4");

    access(1'b0, 8'hFD, 2, 32'h0, "R3");
    access(1'b0, 8'hFE, 2, 32'h0, "R3");
    access(1'b0, 8'hFF, 2, 32'h0, "R3");
    access(1'b0, 8'hFF, 1, 32'h0, "R3");
    access(1'b0, 8'hFC, 3, 32'h0, "R3");

    access(1'b0, 8'h41, 1, 32'h0, "R2");
    access(1'b0, 8'h42, 2, 32'h0, "R2");
    idle();
    idle();

    for (int i = 0; i < 4000; i++) begin
      int off;
      off = ($urandom % 2 == 0) ? int'($urandom % 64) : int'($urandom % 256);
      if ($urandom % 3 == 0) off = off & ~3;
      if ($urandom % 8 == 0) idle();
      else access(1'($urandom % 2), off, int'($urandom % 4), $urandom, "R2");
    end
    idle();

    summary();
    $finish;
  end
endmodule